// File: doc/BRIEF.md
# Region-Policy Two-Way Data Cache

This block is a small two-way set-associative data cache. It sits between a processor-side word port and a main-memory port that moves whole lines. The write policy for each access comes from the address region, through a fixed decoder on the top address nibble. Ordinary memory is handled write-back. One region is handled write-through. Device space bypasses the cache entirely, so a register access always reaches the bus.

Software keeps the cache and memory consistent around DMA transfers that do not snoop the cache. It does this with three per-address maintenance commands:

- **Clean** pushes dirty data out to memory and keeps the line.
- **Invalidate** drops the line.
- **Clean-and-drop** writes the line back and then drops it.

Each accepted request gets exactly one single-cycle response pulse. Read data rides on that pulse.

On a miss the cache fetches a whole line of four words as one burst. The victim is the least recently used way of the addressed set. A dirty victim is written back as a four-beat burst before the fill starts.

Top module: `region_cache`

## Requirements
- R1: A read that hits returns the word the cache holds, even when memory at that address has been changed behind the cache, and it causes no memory traffic.
- R2: A read miss issues one line read at the line-aligned address. Bits [3:2] select the word, bits [6:4] the set, and bits [31:7] are the tag. The line read returns four beats in word order. Later reads of the other words of that line cause no memory traffic.
- R3: The victim is the least recently used of the two ways of the addressed set. A hit or a fill makes its way the most recent. Traffic in one set never evicts a line of another set.
- R4: In the write-back region (top nibble neither 0xE nor 0xF), a write miss allocates the line. A write updates only the cache and leaves memory unchanged. When a dirty line is evicted, its four words are written to memory as a four-beat line write, before the fill read.
- R5: In the write-through region (top nibble 0xE), every write is sent at once as a single-word memory write. A hit also updates the cached word. A write miss does not allocate, and such lines never become dirty.
- R6: In the uncacheable region (top nibble 0xF), every read and every write is a single-word memory transfer. No line is looked up, allocated or transferred.
- R7: Clean (op 2) on a dirty line writes that line back and leaves it valid and clean. Clean on a clean or absent line completes with no memory traffic.
- R8: Invalidate (op 3) clears the line's valid bit without any write-back, discarding dirty data, so the next read refetches from memory. On an absent line it completes with no memory traffic.
- R9: Clean-and-drop (op 4) writes a dirty line back and then clears its valid bit, so memory holds the latest data and the next read refetches.
- R10: While the memory request valid is high and ready is low, the request stays asserted with its address, direction, line flag and write data held stable.
- R11: Op codes are 0 read, 1 write, 2 clean, 3 invalidate and 4 clean-and-drop. Request ready is low from the cycle after acceptance until the response pulse. Exactly one response pulse follows each accepted request.
- R12: After reset there are no valid lines, so the first read misses. After reset, response valid and memory request valid are low and request ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_op | input | 3 | Operation code (see R11) |
| cpu_req_addr | input | 32 | Byte address, word aligned |
| cpu_req_wdata | input | 32 | Write data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | 32 | Read data, valid with the pulse for reads |
| mem_req_valid | output | 1 | Memory request or write beat valid |
| mem_req_ready | input | 1 | Memory accepts the request or beat |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_line | output | 1 | 1 for a line transfer, 0 for a single word |
| mem_req_addr | output | 32 | Byte address of the request or write beat |
| mem_wdata | output | 32 | Write data for the current beat |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rready | output | 1 | Cache accepts a read data beat |
| mem_rdata | input | 32 | Read data beat |

## Verification
Each kind of corrupted internal state shows up at the ports in its own way:

- **Wrong tag or valid bit:** the next access to that set shows the wrong amount of memory traffic, either an extra line read or a missing one. A hit can also return a stale or foreign word on the very next response.
- **Lost dirty bit:** this surfaces only later. A clean, clean-and-drop or eviction of that line skips its four-beat write-back, and memory is then left holding old data that a subsequent refetch exposes.
- **Wrong recency bit:** this shows up one access later, as an eviction of the line that was just used.

The bench therefore checks both returned data and per-operation memory traffic counts on every transaction.

// File: rtl/rcache_pkg.sv
package rcache_pkg;
   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_CLEAN = 3'd2,
      OP_INVAL = 3'd3,
      OP_FLUSH = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      RG_WB = 2'd0,
      RG_WT = 2'd1,
      RG_UC = 2'd2
   } region_e;

   typedef enum logic [2:0] {
      S_IDLE, S_LOOK, S_WB, S_FREQ, S_FILL, S_WORD, S_UCR, S_MDONE
   } state_e;
endpackage

// File: rtl/rcache_region.sv
module rcache_region
   import rcache_pkg::*;
#(
   parameter logic [3:0] NIB_UC    = 4'hF,
   parameter logic [3:0] NIB_WT    = 4'hE,
   parameter bit         WT_ENABLE = 1'b1
) (
   input  logic [3:0] nib,
   output region_e    region
);
   generate
      if (NIB_UC == NIB_WT) begin : g_bad
         $error("rcache_region: region nibbles must differ");
      end
      if (WT_ENABLE) begin : g_wt
         always_comb begin
            if (nib == NIB_UC)      region = RG_UC;
            else if (nib == NIB_WT) region = RG_WT;
            else                    region = RG_WB;
         end
      end else begin : g_nowt
         always_comb region = (nib == NIB_UC) ? RG_UC : RG_WB;
      end
   endgenerate
endmodule

// File: rtl/rcache_lru.sv
module rcache_lru #(
   parameter int SETS = 8,
   parameter int WAYS = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             touch,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] victim
);
   generate
      if (WAYS == 2) begin : g_bit
         logic [SETS-1:0] mru_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     mru_q <= '0;
            else if (touch) mru_q[idx] <= touch_way[0];
         end
         assign victim = WAY_W'(!mru_q[idx]);

         // R3: the way just touched is never the next victim of its set
         a_r3_touch_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
            touch |=> ((idx != $past(idx)) || (victim != $past(touch_way))));
      end else begin : g_bad
         $error("rcache_lru: only two ways are supported");
         assign victim = '0;
      end
   endgenerate
endmodule

// File: rtl/rcache_store.sv
module rcache_store #(
   parameter int SETS   = 8,
   parameter int WAYS   = 2,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 25,
   localparam int IDX_W  = $clog2(SETS),
   localparam int WSEL_W = $clog2(WORDS),
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IDX_W-1:0]       idx,
   input  logic [WAY_W-1:0]       way,
   input  logic                   we,
   input  logic [WSEL_W-1:0]      wsel,
   input  logic [DATA_W-1:0]      wdata,
   input  logic                   mk_dirty,
   input  logic                   install,
   input  logic [TAG_W-1:0]       itag,
   input  logic                   drop_dirty,
   input  logic                   drop_valid,
   output logic [WAYS-1:0][TAG_W-1:0]              rd_tag,
   output logic [WAYS-1:0]                         rd_valid,
   output logic [WAYS-1:0]                         rd_dirty,
   output logic [WAYS-1:0][WORDS-1:0][DATA_W-1:0]  rd_line
);
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic [TAG_W-1:0]  tag_q [SETS];
         logic [DATA_W-1:0] dat_q [SETS][WORDS];
         logic [SETS-1:0]   val_q, dty_q;
         logic              sel;
         assign sel = (way == WAY_W'(w));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q <= '0;
               dty_q <= '0;
            end else if (sel) begin
               if (install)                 val_q[idx] <= 1'b1;
               if (drop_valid)              val_q[idx] <= 1'b0;
               if (mk_dirty)                dty_q[idx] <= 1'b1;
               if (install || drop_dirty || drop_valid) dty_q[idx] <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (sel && we)      dat_q[idx][wsel] <= wdata;
            if (sel && install) tag_q[idx] <= itag;
         end

         assign rd_tag[w]   = tag_q[idx];
         assign rd_valid[w] = val_q[idx];
         assign rd_dirty[w] = dty_q[idx];
         for (genvar k = 0; k < WORDS; k++) begin : g_word
            assign rd_line[w][k] = dat_q[idx][k];
         end
      end
   endgenerate
endmodule

// File: rtl/region_cache.sv
module region_cache
   import rcache_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int SETS   = 8,
   parameter int WAYS   = 2,
   localparam int BYTE_W = $clog2(DATA_W / 8),
   localparam int WSEL_W = $clog2(WORDS),
   localparam int OFF_W  = BYTE_W + WSEL_W,
   localparam int IDX_W  = $clog2(SETS),
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic [2:0]        cpu_req_op,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_resp_valid,
   output logic [DATA_W-1:0] cpu_resp_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic              mem_req_line,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   output logic              mem_rready,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if ((DATA_W % 8) != 0 || (1 << WSEL_W) != WORDS || (1 << IDX_W) != SETS || TAG_W < 1) begin : g_bad
         $error("region_cache: illegal geometry");
      end
   endgenerate

   state_e              state, nxt;
   op_e                 cur_op;
   logic [ADDR_W-1:0]   cur_addr;
   logic [DATA_W-1:0]   cur_wdata;
   logic [WSEL_W-1:0]   beat;
   logic [WAY_W-1:0]    wb_way, wb_way_nxt, hit_way, victim, lru_way;
   logic                lru_touch, resp_set, beat_inc;
   logic [DATA_W-1:0]   resp_data;
   region_e             cur_region;

   wire [TAG_W-1:0]  cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
   wire [IDX_W-1:0]  cur_idx  = cur_addr[OFF_W +: IDX_W];
   wire [WSEL_W-1:0] cur_wsel = cur_addr[BYTE_W +: WSEL_W];

   logic                st_we, st_mk_dirty, st_install, st_drop_dirty, st_drop_valid;
   logic [WAY_W-1:0]    st_way;
   logic [WSEL_W-1:0]   st_wsel;
   logic [DATA_W-1:0]   st_wdata;
   logic [WAYS-1:0][TAG_W-1:0]             rd_tag;
   logic [WAYS-1:0]                        rd_valid, rd_dirty, hit_vec;
   logic [WAYS-1:0][WORDS-1:0][DATA_W-1:0] rd_line;
   logic                hit;

   rcache_region u_region (.nib(cur_addr[ADDR_W-1 -: 4]), .region(cur_region));

   rcache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n), .idx(cur_idx), .touch(lru_touch),
      .touch_way(lru_way), .victim(victim));

   rcache_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .idx(cur_idx), .way(st_way), .we(st_we), .wsel(st_wsel),
      .wdata(st_wdata), .mk_dirty(st_mk_dirty), .install(st_install), .itag(cur_tag),
      .drop_dirty(st_drop_dirty), .drop_valid(st_drop_valid),
      .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_line(rd_line));

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_hit
         assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == cur_tag);
      end
   endgenerate
   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
   end

   assign cpu_req_ready = (state == S_IDLE);

   always_comb begin
      nxt = state;
      st_we = 1'b0; st_mk_dirty = 1'b0; st_install = 1'b0;
      st_drop_dirty = 1'b0; st_drop_valid = 1'b0;
      st_way = hit_way; st_wsel = cur_wsel; st_wdata = cur_wdata;
      lru_touch = 1'b0; lru_way = hit_way;
      resp_set = 1'b0; resp_data = '0;
      wb_way_nxt = wb_way; beat_inc = 1'b0;
      mem_req_valid = 1'b0; mem_req_write = 1'b0; mem_req_line = 1'b0;
      mem_req_addr = cur_addr; mem_wdata = cur_wdata; mem_rready = 1'b0;
      unique case (state)
         S_IDLE: if (cpu_req_valid) nxt = S_LOOK;
         S_LOOK: begin
            if (cur_region == RG_UC && (cur_op == OP_READ || cur_op == OP_WRITE)) begin
               nxt = S_WORD;
            end else begin
               case (cur_op)
                  OP_READ, OP_WRITE: begin
                     if (cur_op == OP_WRITE && cur_region == RG_WT) begin
                        st_we = hit; lru_touch = hit; nxt = S_WORD;
                     end else if (hit) begin
                        st_we = (cur_op == OP_WRITE); st_mk_dirty = (cur_op == OP_WRITE);
                        lru_touch = 1'b1; resp_set = 1'b1;
                        resp_data = rd_line[hit_way][cur_wsel]; nxt = S_IDLE;
                     end else begin
                        wb_way_nxt = victim;
                        nxt = (rd_valid[victim] && rd_dirty[victim]) ? S_WB : S_FREQ;
                     end
                  end
                  OP_CLEAN, OP_FLUSH: begin
                     if (hit && rd_dirty[hit_way]) begin
                        wb_way_nxt = hit_way; nxt = S_WB;
                     end else begin
                        st_drop_valid = hit && (cur_op == OP_FLUSH);
                        resp_set = 1'b1; nxt = S_IDLE;
                     end
                  end
                  OP_INVAL: begin
                     st_drop_valid = hit; resp_set = 1'b1; nxt = S_IDLE;
                  end
                  default: begin resp_set = 1'b1; nxt = S_IDLE; end
               endcase
            end
         end
         S_WB: begin
            mem_req_valid = 1'b1; mem_req_write = 1'b1; mem_req_line = 1'b1;
            mem_req_addr  = {rd_tag[wb_way], cur_idx, beat, {BYTE_W{1'b0}}};
            mem_wdata     = rd_line[wb_way][beat];
            if (mem_req_ready) begin
               beat_inc = 1'b1;
               if (beat == WSEL_W'(WORDS - 1))
                  nxt = (cur_op == OP_READ || cur_op == OP_WRITE) ? S_FREQ : S_MDONE;
            end
         end
         S_FREQ: begin
            mem_req_valid = 1'b1; mem_req_line = 1'b1;
            mem_req_addr  = {cur_tag, cur_idx, {OFF_W{1'b0}}};
            if (mem_req_ready) nxt = S_FILL;
         end
         S_FILL: begin
            mem_rready = 1'b1; st_way = wb_way; st_wsel = beat; st_wdata = mem_rdata;
            if (mem_rvalid) begin
               st_we = 1'b1; beat_inc = 1'b1;
               if (beat == WSEL_W'(WORDS - 1)) begin
                  st_install = 1'b1; lru_touch = 1'b1; lru_way = wb_way; nxt = S_LOOK;
               end
            end
         end
         S_WORD: begin
            mem_req_valid = 1'b1; mem_req_write = (cur_op == OP_WRITE);
            if (mem_req_ready) begin
               resp_set = (cur_op == OP_WRITE);
               nxt = (cur_op == OP_WRITE) ? S_IDLE : S_UCR;
            end
         end
         S_UCR: begin
            mem_rready = 1'b1;
            if (mem_rvalid) begin resp_set = 1'b1; resp_data = mem_rdata; nxt = S_IDLE; end
         end
         S_MDONE: begin
            st_way = wb_way;
            st_drop_dirty = (cur_op == OP_CLEAN);
            st_drop_valid = (cur_op != OP_CLEAN);
            resp_set = 1'b1; nxt = S_IDLE;
         end
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE; cur_op <= OP_READ; cur_addr <= '0; cur_wdata <= '0;
         beat <= '0; wb_way <= '0; cpu_resp_valid <= 1'b0; cpu_resp_rdata <= '0;
      end else begin
         state  <= nxt;
         wb_way <= wb_way_nxt;
         cpu_resp_valid <= resp_set;
         if (resp_set) cpu_resp_rdata <= resp_data;
         if (state == S_LOOK) beat <= '0;
         else if (beat_inc)   beat <= beat + 1'b1;
         if (state == S_IDLE && cpu_req_valid) begin
            cur_op <= op_e'(cpu_req_op); cur_addr <= cpu_req_addr; cur_wdata <= cpu_req_wdata;
         end
      end
   end

   // R10: memory request held while stalled
   a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
       $stable(mem_req_write) && $stable(mem_req_line) && $stable(mem_wdata)));
   // R11: busy after acceptance
   a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);
   // R6: device space never touches the arrays or the line channel
   a_r6_uc_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE && cur_region == RG_UC) |-> !(st_we || st_install || mem_req_line));
   // R4: write-back region never emits single-word writes
   a_r4_wb_no_word_write: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE && cur_region == RG_WB) |-> !(mem_req_valid && mem_req_write && !mem_req_line));
   // R5: write-through lines are never dirty
   a_r5_wt_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_LOOK && cur_region == RG_WT && hit) |-> !rd_dirty[hit_way]);
   // R7: a cleaned line stays valid and becomes clean
   a_r7_clean_keeps_line: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_MDONE && cur_op == OP_CLEAN) |=> (rd_valid[$past(wb_way)] && !rd_dirty[$past(wb_way)]));
endmodule

// File: tb/region_cache_tb.sv
module region_cache_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] RD = 3'd0, WR = 3'd1, CL = 3'd2, IV = 3'd3, CI = 3'd4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic        cpu_req_valid = 1'b0, cpu_req_ready;
   logic [2:0]  cpu_req_op = '0;
   logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
   logic        cpu_resp_valid;
   logic [31:0] cpu_resp_rdata;
   logic        mem_req_valid, mem_req_ready = 1'b0, mem_req_write, mem_req_line;
   logic [31:0] mem_req_addr, mem_wdata;
   logic        mem_rvalid = 1'b0, mem_rready;
   logic [31:0] mem_rdata = '0;

   region_cache u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_op(cpu_req_op),
      .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
      .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_line(mem_req_line), .mem_req_addr(mem_req_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rready(mem_rready), .mem_rdata(mem_rdata));

   // behavioural memory and traffic counters
   logic [31:0] memory [logic [31:0]];
   logic [31:0] beatq [$];
   int checks = 0, errors = 0, cyc = 0;
   int lrd = 0, lwr = 0, wwr = 0, wrd = 0;
   int b_lrd, b_lwr, b_wwr, b_wrd;
   int hold_bad = 0, proto_bad = 0;
   logic prev_stall = 1'b0, outstanding = 1'b0;
   logic [31:0] prev_addr = '0;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return a ^ 32'h5A5A_0000 ^ {a[15:0], 16'h0};
   endfunction
   function automatic logic [31:0] mrd(input logic [31:0] a);
      return memory.exists(a) ? memory[a] : pat(a);
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         mem_req_ready = 1'b0; mem_rvalid = 1'b0;
      end else begin
         if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_bad++;
         mem_req_ready = (cyc % 4) != 1;
         prev_stall = mem_req_valid && !mem_req_ready;
         prev_addr  = mem_req_addr;
         if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
               memory[mem_req_addr] = mem_wdata;
               if (mem_req_line) lwr++; else wwr++;
            end else if (mem_req_line) begin
               lrd++;
               for (int k = 0; k < 4; k++) beatq.push_back(mem_req_addr + 32'(4 * k));
            end else begin
               wrd++; beatq.push_back(mem_req_addr);
            end
         end
         if (mem_rready && beatq.size() > 0 && (cyc % 5) != 2) begin
            mem_rvalid = 1'b1; mem_rdata = mrd(beatq.pop_front());
         end else begin
            mem_rvalid = 1'b0;
         end
         // R11 per-clock protocol comparison
         if (cpu_resp_valid && !outstanding) proto_bad++;
         if (outstanding && !cpu_resp_valid && cpu_req_ready) proto_bad++;
         if (cpu_resp_valid) outstanding = 1'b0;
         if (cpu_req_valid && cpu_req_ready) outstanding = 1'b1;
      end
   end

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic snap();
      b_lrd = lrd; b_lwr = lwr; b_wwr = wwr; b_wrd = wrd;
   endtask

   // packed traffic: {line reads, line write beats, word writes, word reads}
   task automatic traffic(input string r, input logic [31:0] exp);
      chk(r, {8'(lrd - b_lrd), 8'(lwr - b_lwr), 8'(wwr - b_wwr), 8'(wrd - b_wrd)}, exp);
   endtask

   task automatic cpu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] q);
      snap();
      @(posedge clk); #1;
      cpu_req_valid = 1'b1; cpu_req_op = op; cpu_req_addr = a; cpu_req_wdata = d;
      do @(negedge clk); while (!cpu_req_ready);
      @(posedge clk); #1;
      cpu_req_valid = 1'b0;
      while (!cpu_resp_valid) @(negedge clk);
      q = cpu_resp_rdata;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] q;
      logic [31:0] A, B, C, D, E, U, F;
      A = 32'h0000_1000; B = 32'h0000_1080; C = 32'h0000_1100; D = 32'h0000_1010;
      E = 32'hE000_0020; U = 32'hF000_0040; F = 32'h0000_2030;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R12 ready after reset", {31'd0, cpu_req_ready}, 32'd1);
      chk("R12 resp low after reset", {31'd0, cpu_resp_valid}, 32'd0);
      chk("R12 mem req low after reset", {31'd0, mem_req_valid}, 32'd0);

      // R2 / R12: first read misses, fetches a whole line
      cpu(RD, A, 0, q);  chk("R2 miss data", q, pat(A));  traffic("R12 first read line fetch", 32'h01000000);
      cpu(RD, A + 4, 0, q);  chk("R2 word1", q, pat(A + 4));
      cpu(RD, A + 8, 0, q);  chk("R2 word2", q, pat(A + 8));
      cpu(RD, A + 12, 0, q); chk("R2 word3", q, pat(A + 12)); traffic("R2 no traffic in line", 0);

      // R4 / R1: write-back write stays in cache
      cpu(WR, A + 4, 32'h1111_1111, q); traffic("R4 wb write no traffic", 0);
      chk("R4 memory unchanged", mrd(A + 4), pat(A + 4));
      cpu(RD, A + 4, 0, q); chk("R1 hit returns written word", q, 32'h1111_1111);

      // R7: clean
      cpu(CL, A, 0, q); traffic("R7 clean writes back line", 32'h00040000);
      chk("R7 memory updated", mrd(A + 4), 32'h1111_1111);
      cpu(RD, A + 4, 0, q); chk("R7 line kept", q, 32'h1111_1111); traffic("R7 still hits", 0);
      cpu(CL, A, 0, q); traffic("R7 clean on clean line", 0);
      cpu(CL, 32'h0000_3000, 0, q); traffic("R7 clean on absent line", 0);

      // R1 / R8: stale data after DMA, invalidate refetches
      memory[A + 8] = 32'hD0D0_D0D0;
      cpu(RD, A + 8, 0, q); chk("R1 stale hit", q, pat(A + 8)); traffic("R1 stale hit no traffic", 0);
      cpu(IV, A, 0, q); traffic("R8 invalidate no traffic", 0);
      cpu(RD, A + 8, 0, q); chk("R8 refetch fresh", q, 32'hD0D0_D0D0); traffic("R8 refetch", 32'h01000000);
      cpu(IV, 32'h0000_3000, 0, q); traffic("R8 invalidate absent", 0);

      // R3: LRU within set 0, set 1 untouched
      cpu(RD, D, 0, q); chk("R3 other set load", q, pat(D));
      cpu(RD, B, 0, q); chk("R3 B", q, pat(B));
      cpu(RD, A, 0, q); traffic("R3 A hit", 0);
      cpu(RD, C, 0, q); chk("R3 C", q, pat(C)); traffic("R3 C evicts clean B", 32'h01000000);
      cpu(RD, A, 0, q); traffic("R3 A survives", 0);
      cpu(RD, B, 0, q); traffic("R3 B was evicted", 32'h01000000);
      cpu(RD, D, 0, q); chk("R3 other set data", q, pat(D)); traffic("R3 other set kept", 0);

      // R4: dirty eviction
      cpu(WR, A, 32'h2222_2222, q); traffic("R4 write hit", 0);
      cpu(RD, B, 0, q); traffic("R4 B hit", 0);
      cpu(RD, C, 0, q); chk("R4 C data", q, pat(C));
      traffic("R4 writeback then fill", 32'h01040000);
      chk("R4 evicted data in memory", mrd(A), 32'h2222_2222);

      // R5: write-through
      cpu(WR, E, 32'h3333_3333, q); traffic("R5 wt miss word write", 32'h00000100);
      chk("R5 wt memory", mrd(E), 32'h3333_3333);
      cpu(RD, E, 0, q); chk("R5 no allocate data", q, 32'h3333_3333); traffic("R5 no allocate", 32'h01000000);
      cpu(WR, E, 32'h4444_4444, q); traffic("R5 wt hit word write", 32'h00000100);
      chk("R5 wt hit memory", mrd(E), 32'h4444_4444);
      cpu(RD, E, 0, q); chk("R5 cache updated", q, 32'h4444_4444); traffic("R5 hit after wt", 0);
      cpu(CL, E, 0, q); traffic("R5 wt line never dirty", 0);

      // R6: uncacheable
      cpu(WR, U, 32'h5555_5555, q); traffic("R6 uc write", 32'h00000100);
      cpu(RD, U, 0, q); chk("R6 uc read", q, 32'h5555_5555); traffic("R6 uc read word", 32'h00000001);
      memory[U] = 32'h6666_6666;
      cpu(RD, U, 0, q); chk("R6 uc sees device", q, 32'h6666_6666); traffic("R6 uc read again", 32'h00000001);

      // R9: clean-and-drop
      cpu(WR, F, 32'h7777_7777, q); traffic("R4 write miss allocates", 32'h01000000);
      cpu(CI, F, 0, q); traffic("R9 writeback", 32'h00040000);
      chk("R9 memory", mrd(F), 32'h7777_7777);
      memory[F] = 32'h8888_8888;
      cpu(RD, F, 0, q); chk("R9 refetch", q, 32'h8888_8888); traffic("R9 dropped", 32'h01000000);

      // R8: invalidate discards dirty data
      cpu(WR, F, 32'h9999_9999, q);
      cpu(IV, F, 0, q); traffic("R8 no writeback", 0);
      cpu(RD, F, 0, q); chk("R8 dirty discarded", q, 32'h8888_8888); traffic("R8 refetch", 32'h01000000);

      repeat (4) @(negedge clk);
      chk("R10 stall hold violations", 32'(hold_bad), 0);
      chk("R11 handshake violations", 32'(proto_bad), 0);
      summary();
      $finish;
   end
endmodule